// File: doc/BRIEF.md
# Dual-Mode Serial Clock Divider

This block derives the serial clock of a synchronous serial port from the module clock. Two division schemes share one 13-bit control word: a linear even divider, where the output period is 2·(n+1) module cycles for an 8-bit setting n, and a power-of-two divider, where the period is 2^(n+1) module cycles for a 4-bit setting n. One bit of the word picks the scheme.

The transfer engine raises `burst_run` for the duration of a burst while `div_enable` is high. Outside a burst the serial clock rests at the polarity level. During a burst it toggles after every half period. Each toggle is reported by a one-cycle pulse: `lead_tick` when the clock leaves its resting level and `trail_tick` when it returns to it. The engine uses these pulses to sample and shift. The divider setting and the polarity are captured while the block is idle, so they stay frozen for the whole burst. Computing a setting from a target frequency is done by software.

Top module: `sclk_gen_dual`

## Requirements
- R1: With control bit 12 = 1 (linear scheme), the serial clock changes level every n+1 module cycles, where n is control bits 7:0, so the full period is 2·(n+1) cycles.
- R2: With control bit 12 = 0 (power-of-two scheme), the serial clock changes level every 2^n module cycles, where n is control bits 11:8, so the full period is 2^(n+1) cycles.
- R3: A linear setting of n = 0 makes the serial clock change level on every module clock, giving half the module clock frequency.
- R4: Whenever no burst is active (either `burst_run` or `div_enable` is low), `sclk_out` equals the `clk_polarity` level sampled at the previous edge. When a burst ends, `sclk_out` returns to that level one cycle later.
- R5: The first change of the serial clock comes H module cycles after the first active edge of a burst, where H is the half period. That change and every second change after it raise `lead_tick` for the one cycle in which `sclk_out` shows the new level. The other changes raise `trail_tick` in the same way. The two pulses are never high together.
- R6: A change of the control word while a burst is running has no effect on that burst. The new setting is used from the next burst.
- R7: `lead_tick` and `trail_tick` are 0 whenever no burst is active. The half-period count restarts at every burst, so the first edge of each burst comes at the same offset.
- R8: With `div_enable` low, a high `burst_run` produces no clock edges and no tick pulses.
- R9: While `rst_n` is low, `sclk_out`, `lead_tick` and `trail_tick` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_enable | input | 1 | Divider enable |
| burst_run | input | 1 | High while the transfer engine runs a burst |
| clk_polarity | input | 1 | Resting level of the serial clock |
| div_ctl | input | 13 | Bits 7:0 linear setting, bits 11:8 power-of-two setting, bit 12 scheme select (1 = linear) |
| sclk_out | output | 1 | Serial clock level |
| lead_tick | output | 1 | One-cycle pulse when the serial clock leaves its resting level |
| trail_tick | output | 1 | One-cycle pulse when the serial clock returns to its resting level |

## Verification
The assertions assume that `clk_polarity` is held steady from at least one cycle before a burst starts until the burst ends. They do not assume the control word is stable, because the frozen setting is one of the checked properties. The stimulus sets polarity and control word during two idle cycles before raising `burst_run`, and changes only the control word during a burst. Power-of-two settings in the random part are kept small so that several full periods fit in every burst.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;

  typedef enum logic {
    MODE_POW2   = 1'b0,
    MODE_LINEAR = 1'b1
  } div_mode_e;

  // Terminal value of the half-period counter: half period minus one.
  function automatic int unsigned half_terminal(input div_mode_e mode,
                                                input int unsigned lin_n,
                                                input int unsigned exp_n);
    if (mode == MODE_LINEAR) return lin_n;
    return (32'd1 << exp_n) - 32'd1;
  endfunction

endpackage

// File: rtl/sclk_setting_hold.sv
module sclk_setting_hold
  import sclk_div_pkg::*;
#(
  parameter int LIN_W = 8,
  parameter int EXP_W = 4,
  parameter int CNT_W = 15
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       active,
  input  logic [LIN_W+EXP_W:0]       ctl_word,
  input  logic                       pol_in,
  output logic [CNT_W-1:0]           term_q,
  output logic                       pol_q
);
  localparam int SEL_BIT = LIN_W + EXP_W;

  div_mode_e   mode_w;
  logic [CNT_W-1:0] term_w;

  assign mode_w = div_mode_e'(ctl_word[SEL_BIT]);
  assign term_w = CNT_W'(half_terminal(mode_w,
                                       32'(ctl_word[LIN_W-1:0]),
                                       32'(ctl_word[SEL_BIT-1:LIN_W])));

  // Capture only while idle: the setting is frozen for a running burst.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      term_q <= '0;
      pol_q  <= 1'b0;
    end else if (!active) begin
      term_q <= term_w;
      pol_q  <= pol_in;
    end
  end
endmodule

// File: rtl/sclk_half_counter.sv
module sclk_half_counter #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [CNT_W-1:0] term,
  output logic [CNT_W-1:0] cnt_q,
  output logic             half_done
);
  assign half_done = active && (cnt_q == term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!active)    cnt_q <= '0;
    else if (half_done)  cnt_q <= '0;
    else                 cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/sclk_edge_gen.sv
module sclk_edge_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic half_done,
  input  logic pol_live,
  input  logic pol_held,
  output logic sclk_q,
  output logic lead_q,
  output logic trail_q
);
  logic at_rest;
  assign at_rest = (sclk_q == pol_held);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else if (!active) begin
      sclk_q  <= pol_live;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      lead_q  <= half_done && at_rest;
      trail_q <= half_done && !at_rest;
      if (half_done) sclk_q <= ~sclk_q;
    end
  end
endmodule

// File: rtl/sclk_gen_dual.sv
module sclk_gen_dual #(
  parameter int LIN_W = 8,
  parameter int EXP_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   div_enable,
  input  logic                   burst_run,
  input  logic                   clk_polarity,
  input  logic [LIN_W+EXP_W:0]   div_ctl,
  output logic                   sclk_out,
  output logic                   lead_tick,
  output logic                   trail_tick
);
  localparam int EXP_SPAN = (1 << EXP_W) - 1;
  localparam int CNT_W    = (LIN_W > EXP_SPAN) ? LIN_W : EXP_SPAN;

  logic             burst_active;
  logic [CNT_W-1:0] term_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pol_q;
  logic             half_done;

  assign burst_active = div_enable && burst_run;

  sclk_setting_hold #(.LIN_W(LIN_W), .EXP_W(EXP_W), .CNT_W(CNT_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (burst_active),
    .ctl_word (div_ctl),
    .pol_in   (clk_polarity),
    .term_q   (term_q),
    .pol_q    (pol_q)
  );

  sclk_half_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (burst_active),
    .term      (term_q),
    .cnt_q     (cnt_q),
    .half_done (half_done)
  );

  sclk_edge_gen u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (burst_active),
    .half_done (half_done),
    .pol_live  (clk_polarity),
    .pol_held  (pol_q),
    .sclk_q    (sclk_out),
    .lead_q    (lead_tick),
    .trail_q   (trail_tick)
  );
endmodule

// File: rtl/sclk_gen_dual_chk.sv
module sclk_gen_dual_chk #(
  parameter int CNT_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             active,
  input logic             pol,
  input logic             pol_q,
  input logic [CNT_W-1:0] term_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             sclk,
  input logic             lead,
  input logic             trail
);
  p_idle_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (sclk == $past(pol)));

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!lead && !trail));

  p_tick_moves_sclk_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lead || trail) |-> (sclk != $past(sclk)));

  p_lead_leaves_rest_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lead |-> (sclk != pol_q));

  p_single_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead && trail));

  p_setting_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(term_q));

  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= term_q);
endmodule

bind sclk_gen_dual sclk_gen_dual_chk #(.CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .active (burst_active),
  .pol    (clk_polarity),
  .pol_q  (pol_q),
  .term_q (term_q),
  .cnt_q  (cnt_q),
  .sclk   (sclk_out),
  .lead   (lead_tick),
  .trail  (trail_tick)
);

// File: tb/test_sclk_gen_dual.sv
module test_sclk_gen_dual;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 180000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        div_enable = 1'b0;
  logic        burst_run = 1'b0;
  logic        clk_polarity = 1'b0;
  logic [12:0] div_ctl = '0;
  logic        sclk_out, lead_tick, trail_tick;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sclk_gen_dual i_sclk_gen_dual (
    .clk(clk), .rst_n(rst_n), .div_enable(div_enable), .burst_run(burst_run),
    .clk_polarity(clk_polarity), .div_ctl(div_ctl),
    .sclk_out(sclk_out), .lead_tick(lead_tick), .trail_tick(trail_tick)
  );

  // Half period in module cycles, straight from the rates in R1/R2.
  function automatic int half_of(input logic [12:0] c);
    int lin_period, exp_period;
    lin_period = 2 * (int'(c[7:0]) + 1);
    exp_period = 2 ** (int'(c[11:8]) + 1);
    return (c[12] ? lin_period : exp_period) / 2;
  endfunction

  function automatic logic [12:0] lin_word(input int n);
    return {1'b1, 4'h0, n[7:0]};
  endfunction

  function automatic logic [12:0] exp_word(input int n);
    return {1'b0, n[3:0], 8'h5a};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One burst: idle setup, nsamp active cycles compared against the
  // expected waveform, then the end-of-burst level.
  task automatic do_burst(input logic [12:0] ctl, input logic pol, input int nsamp,
                          input bit swap, input logic [12:0] ctl2, input string req);
    int h, bad, bad_s, got, want;
    h = half_of(ctl);
    bad = 0; bad_s = -1; got = 0; want = 0;
    div_ctl = ctl; clk_polarity = pol; div_enable = 1'b1; burst_run = 1'b0;
    repeat (2) @(negedge clk);
    burst_run = 1'b1;
    for (int s = 1; s <= nsamp; s++) begin
      int k;
      logic es, el, et;
      @(negedge clk);
      k  = s / h;
      es = pol ^ k[0];
      el = ((s % h) == 0) && k[0];
      et = ((s % h) == 0) && !k[0] && (k > 0);
      if (sclk_out !== es || lead_tick !== el || trail_tick !== et) begin
        if (bad == 0) begin
          bad_s = s;
          got   = {sclk_out, lead_tick, trail_tick};
          want  = {es, el, et};
        end
        bad++;
      end
      if (swap && s == 2) div_ctl = ctl2;
    end
    check(bad == 0, req, "waveform {sclk,lead,trail} at first bad cycle", got, want);
    if (bad != 0) $display("      first mismatch at active cycle %0d, h=%0d", bad_s, h);
    burst_run = 1'b0;
    @(negedge clk);
    check(sclk_out === pol, "R4", "sclk after burst end", sclk_out, pol);
    check(!lead_tick && !trail_tick, "R7", "ticks after burst end",
          {lead_tick, trail_tick}, 0);
  endtask

  initial begin
    int wd;
    wd = 0;
    while (!done) begin
      @(posedge clk);
      wd++;
      if (wd > WATCHDOG) begin
        checks++; fails++;
        $display("FAIL watchdog: run hung actual=%0d expected<%0d", wd, WATCHDOG);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R9: reset state
    repeat (3) @(negedge clk);
    check(sclk_out === 1'b0 && !lead_tick && !trail_tick, "R9", "outputs in reset",
          {sclk_out, lead_tick, trail_tick}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: idle level follows polarity
    clk_polarity = 1'b1;
    @(negedge clk);
    check(sclk_out === 1'b1, "R4", "idle sclk with polarity 1", sclk_out, 1);

    // Directed corner cases
    do_burst(lin_word(0),   1'b0, 12,   0, '0, "R3");
    do_burst(lin_word(0),   1'b1, 9,    0, '0, "R3");
    do_burst(lin_word(3),   1'b0, 40,   0, '0, "R1");
    do_burst(lin_word(255), 1'b1, 1100, 0, '0, "R1");
    do_burst(exp_word(0),   1'b0, 10,   0, '0, "R2");
    do_burst(exp_word(4),   1'b1, 70,   0, '0, "R2");
    do_burst(exp_word(9),   1'b0, 2100, 0, '0, "R2");
    // R5: tick placement on an odd half period
    do_burst(lin_word(6),   1'b1, 57,   0, '0, "R5");
    // R6: change mid-burst ignored, used in next burst
    do_burst(lin_word(5),   1'b0, 50,   1, lin_word(1), "R6");
    do_burst(lin_word(1),   1'b0, 20,   0, '0, "R6");
    do_burst(exp_word(3),   1'b1, 45,   1, lin_word(0), "R6");
    // R7: restart after a burst cut mid-period keeps first-edge offset
    do_burst(lin_word(9),   1'b0, 15,   0, '0, "R7");
    do_burst(lin_word(9),   1'b0, 45,   0, '0, "R7");

    // R8: enable low blocks the burst
    begin
      int bad;
      bad = 0;
      clk_polarity = 1'b1; div_ctl = lin_word(0); div_enable = 1'b0;
      @(negedge clk);
      burst_run = 1'b1;
      for (int s = 0; s < 30; s++) begin
        @(negedge clk);
        if (sclk_out !== 1'b1 || lead_tick || trail_tick) bad++;
      end
      check(bad == 0, "R8", "cycles with activity while disabled", bad, 0);
      burst_run = 1'b0; div_enable = 1'b1;
      @(negedge clk);
    end

    // Random bursts
    for (int i = 0; i < 24; i++) begin
      logic [12:0] c, c2;
      logic p;
      int h, n;
      p = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 1) == 1) c = lin_word(int'($urandom_range(0, 255)));
      else                           c = exp_word(int'($urandom_range(0, 6)));
      c2 = lin_word(int'($urandom_range(0, 255)));
      h = half_of(c);
      n = 4 * h + int'($urandom_range(0, 7));
      do_burst(c, p, n, (i % 3) == 0, c2, c[12] ? "R1" : "R2");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule